// File: doc/BRIEF.md
# Preemptive Priority Interrupt Controller

This block gathers interrupt requests from level-sensitive hardware lines and from a small bank of software-posted requests. Each source carries a 4-bit priority; zero turns the source off. Each cycle the block picks the pending source with the highest priority, and breaks ties toward the lowest source index. It then compares that priority with the priority now being serviced. The processor interrupt is raised only when the winner would strictly preempt the running handler. The vector that goes with it is the source index itself.

Software controls the block through a few strobed commands: write a source priority, write the current priority directly (for a priority ceiling), set or clear a software request, acknowledge, and end of interrupt. An acknowledge pushes the interrupted priority and the source index onto a 16-entry stack. It also takes on the source's priority and masks that source until its end of interrupt. An end of interrupt pops the stack. A high-priority handler can post a software request at a lower level to finish its work later.

Top module: `pic_preempt`

## Requirements
- R1: After reset, `irq` is 0, `cur_prio` is 0, `eoi_underflow` is 0, every priority is 0 and no software request is set.
- R2: `irq` is asserted only when the selected source's priority is strictly greater than `cur_prio`, evaluated on the clock edge after the inputs settle (one register stage).
- R3: `vector` equals the selected source index. Software requests are sources 0 to N_SW-1, and `hw_req[k]` is source N_SW+k.
- R4: Among pending sources of equal highest priority, the lowest index is selected.
- R5: A source with priority 0 never causes `irq`.
- R6: `prio_we` writes `prio_val` to the source `prio_idx` at run time, and this changes the selection.
- R7: `cur_we` writes `cur_val` to `cur_prio` when no acknowledge or end of interrupt is accepted in the same cycle.
- R8: `sw_we` with `sw_val`=1 sets software request `sw_idx`, and with 0 clears it. A set request stays pending across acknowledge and end of interrupt until cleared.
- R9: An acknowledge taken while `irq` is 1 pushes `cur_prio`, sets `cur_prio` to the vector's priority, masks that source and drops `irq` on the next cycle.
- R10: An end of interrupt with a non-empty stack restores the popped priority into `cur_prio` and unmasks the source stored in that entry.
- R11: An end of interrupt with an empty stack leaves `cur_prio` unchanged and sets the sticky `eoi_underflow`.
- R12: An acknowledge while `irq` is 0, or while the stack holds 16 entries, has no effect. An acknowledge takes precedence over an end of interrupt in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_req | input | N_HW | Level hardware requests, source N_SW+k |
| prio_we | input | 1 | Priority write strobe |
| prio_idx | input | IDX_W | Source whose priority is written |
| prio_val | input | PRIO_W | New priority, 0 disables |
| cur_we | input | 1 | Current-priority write strobe |
| cur_val | input | PRIO_W | New current priority |
| sw_we | input | 1 | Software request write strobe |
| sw_idx | input | SWI_W | Software request index |
| sw_val | input | 1 | 1 sets, 0 clears |
| ack | input | 1 | Acknowledge of the presented vector |
| eoi | input | 1 | End of interrupt |
| irq | output | 1 | Interrupt to the processor |
| vector | output | IDX_W | Source index of the request |
| cur_prio | output | PRIO_W | Priority now in service |
| eoi_underflow | output | 1 | Sticky: end of interrupt on empty stack |

## Verification
The bench checks equal-priority ties, and a wrong comparison direction would report the higher index. It checks a current priority equal to the request, where a non-strict compare would interrupt anyway. It takes a nested acknowledge and end of interrupt and then watches the restored level: a design that forgot to unmask would keep a pending source silent. It fills the 16-deep stack and tries a seventeenth acknowledge, which a design without a full guard would accept and then corrupt the current priority. It also sends an end of interrupt to an empty stack, which must leave the current priority intact and raise the sticky flag.

// File: rtl/pic_preempt.sv
module pic_preempt #(
  parameter int N_SW      = 8,
  parameter int N_HW      = 24,
  parameter int PRIO_W    = 4,
  parameter int STK_DEPTH = 16,
  localparam int N_SRC    = N_SW + N_HW,
  localparam int IDX_W    = $clog2(N_SRC),
  localparam int SWI_W    = $clog2(N_SW),
  localparam int SP_W     = $clog2(STK_DEPTH + 1),
  localparam int STK_AW   = $clog2(STK_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_HW-1:0]   hw_req,
  input  logic              prio_we,
  input  logic [IDX_W-1:0]  prio_idx,
  input  logic [PRIO_W-1:0] prio_val,
  input  logic              cur_we,
  input  logic [PRIO_W-1:0] cur_val,
  input  logic              sw_we,
  input  logic [SWI_W-1:0]  sw_idx,
  input  logic              sw_val,
  input  logic              ack,
  input  logic              eoi,
  output logic              irq,
  output logic [IDX_W-1:0]  vector,
  output logic [PRIO_W-1:0] cur_prio,
  output logic              eoi_underflow
);

  logic [PRIO_W-1:0] prio [N_SRC];
  logic [N_SW-1:0]   sw_pend;
  logic [N_SRC-1:0]  in_svc, pend;
  logic [PRIO_W-1:0] best_prio, sel_prio_q;
  logic [IDX_W-1:0]  best_idx;
  logic [PRIO_W-1:0] stk_prio [STK_DEPTH];
  logic [IDX_W-1:0]  stk_src  [STK_DEPTH];
  logic [SP_W-1:0]   sp;
  logic              ack_ok, eoi_ok, eoi_bad;
  logic [STK_AW-1:0] top, push_at;

  assign pend    = {hw_req, sw_pend} & ~in_svc;
  assign ack_ok  = ack && irq && (sp != SP_W'(STK_DEPTH));
  assign eoi_ok  = eoi && !ack_ok && (sp != '0);
  assign eoi_bad = eoi && !ack_ok && (sp == '0);
  assign top     = STK_AW'(sp - 1'b1);
  assign push_at = STK_AW'(sp);

  always_comb begin
    best_prio = '0;
    best_idx  = '0;
    for (int i = 0; i < N_SRC; i++)
      if (pend[i] && prio[i] > best_prio) begin
        best_prio = prio[i];
        best_idx  = IDX_W'(i);
      end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      irq        <= 1'b0;
      vector     <= '0;
      sel_prio_q <= '0;
    end else begin
      irq        <= !ack_ok && (best_prio > cur_prio);
      vector     <= best_idx;
      sel_prio_q <= best_prio;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < N_SRC; i++) prio[i] <= '0;
      sw_pend <= '0;
    end else begin
      if (prio_we) prio[prio_idx] <= prio_val;
      if (sw_we)   sw_pend[sw_idx] <= sw_val;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cur_prio      <= '0;
      in_svc        <= '0;
      sp            <= '0;
      eoi_underflow <= 1'b0;
      for (int i = 0; i < STK_DEPTH; i++) begin
        stk_prio[i] <= '0;
        stk_src[i]  <= '0;
      end
    end else if (ack_ok) begin
      stk_prio[push_at] <= cur_prio;
      stk_src[push_at]  <= vector;
      sp                <= sp + 1'b1;
      cur_prio          <= sel_prio_q;
      in_svc[vector]    <= 1'b1;
    end else if (eoi_ok) begin
      cur_prio             <= stk_prio[top];
      in_svc[stk_src[top]] <= 1'b0;
      sp                   <= sp - 1'b1;
    end else begin
      if (eoi_bad) eoi_underflow <= 1'b1;
      if (cur_we)  cur_prio <= cur_val;
    end

  AST_STRICT_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> sel_prio_q > $past(cur_prio));  // R2
  AST_NO_ZERO_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> sel_prio_q != '0);  // R5
  AST_ACK_TAKES_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq && sp < SP_W'(STK_DEPTH)) |=> (cur_prio == $past(sel_prio_q)) && !irq);  // R9
  AST_SVC_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !in_svc[vector]);  // R9
  AST_EOI_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !ack && sp != '0) |=> cur_prio == $past(stk_prio[top]));  // R10
  AST_UNDERFLOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !ack && !cur_we && sp == '0) |=> eoi_underflow && $stable(cur_prio));  // R11
  AST_FULL_STACK: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !eoi && sp == SP_W'(STK_DEPTH)) |=> sp == SP_W'(STK_DEPTH));  // R12
  AST_SP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= SP_W'(STK_DEPTH));  // R12

endmodule

// File: tb/tb_pic_preempt.sv
module tb_pic_preempt;
  localparam int N_SW = 8, N_HW = 24, IDX_W = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N_HW-1:0] hw_req = '0;
  logic prio_we = 0, cur_we = 0, sw_we = 0, sw_val = 0, ack = 0, eoi = 0;
  logic [IDX_W-1:0] prio_idx = '0;
  logic [3:0] prio_val = '0, cur_val = '0;
  logic [2:0] sw_idx = '0;
  logic irq, eoi_underflow;
  logic [IDX_W-1:0] vector;
  logic [3:0] cur_prio;

  always #4 clk = ~clk;

  pic_preempt dut (.clk(clk), .rst_n(rst_n), .hw_req(hw_req), .prio_we(prio_we),
    .prio_idx(prio_idx), .prio_val(prio_val), .cur_we(cur_we), .cur_val(cur_val),
    .sw_we(sw_we), .sw_idx(sw_idx), .sw_val(sw_val), .ack(ack), .eoi(eoi),
    .irq(irq), .vector(vector), .cur_prio(cur_prio), .eoi_underflow(eoi_underflow));

  typedef struct {
    bit    irq;
    int    vec;
    int    cur;
    int    uf;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  event chk_ev;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic expect_out(bit i, int v, int c, int u, string tag);
    exp_t e;
    e.irq = i; e.vec = v; e.cur = c; e.uf = u; e.tag = tag;
    exp_q.push_back(e);
    -> chk_ev;
  endtask

  initial forever begin
    @(chk_ev);
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_chk++;
      if (irq !== e.irq || (e.irq && e.vec >= 0 && int'(vector) != e.vec) ||
          (e.cur >= 0 && int'(cur_prio) != e.cur) ||
          (e.uf >= 0 && int'(eoi_underflow) != e.uf)) begin
        n_fail++;
        $display("FAIL %s: irq=%0d vec=%0d cur=%0d uf=%0d, expected irq=%0d vec=%0d cur=%0d uf=%0d",
                 e.tag, irq, vector, cur_prio, eoi_underflow, e.irq, e.vec, e.cur, e.uf);
      end
    end
  end

  task automatic set_prio(int idx, int val);
    prio_we = 1; prio_idx = IDX_W'(idx); prio_val = 4'(val); tick(); prio_we = 0;
  endtask
  task automatic set_cur(int val);
    cur_we = 1; cur_val = 4'(val); tick(); cur_we = 0;
  endtask
  task automatic set_sw(int idx, bit val);
    sw_we = 1; sw_idx = 3'(idx); sw_val = val; tick(); sw_we = 0;
  endtask
  task automatic do_ack();
    ack = 1; tick(); ack = 0;
  endtask
  task automatic do_eoi();
    eoi = 1; tick(); eoi = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    repeat (3) tick();
    rst_n = 1; tick();
    expect_out(0, -1, 0, 0, "R1");

    hw_req[5] = 1; tick(); tick();
    expect_out(0, -1, 0, 0, "R5");

    set_prio(13, 3); tick();
    expect_out(1, 13, 0, 0, "R6 R3");

    set_cur(3); tick();
    expect_out(0, -1, 3, 0, "R7 R2 equal");
    set_cur(2); tick();
    expect_out(1, 13, 2, 0, "R2");

    set_cur(0);
    hw_req[12] = 1; set_prio(20, 3); tick();
    expect_out(1, 13, 0, 0, "R4");
    set_prio(20, 4); tick();
    expect_out(1, 20, 0, 0, "R6");
    set_sw(2, 1); set_prio(2, 4); tick();
    expect_out(1, 2, 0, 0, "R8 R4");

    do_ack();
    expect_out(0, -1, 4, 0, "R9");
    tick();
    expect_out(0, -1, 4, 0, "R9 masked");

    set_prio(13, 6); tick();
    expect_out(1, 13, 4, 0, "R2 nested");
    do_ack();
    expect_out(0, -1, 6, 0, "R9 nested");
    do_eoi();
    expect_out(0, -1, 4, 0, "R10");
    tick();
    expect_out(1, 13, 4, 0, "R10 unmask");
    do_eoi();
    expect_out(1, 13, 0, 0, "R10 outer");
    set_prio(13, 0); tick();
    expect_out(1, 2, 0, 0, "R8 persists");
    set_sw(2, 0); tick();
    expect_out(1, 20, 0, 0, "R8 clear");

    set_cur(15); tick();
    expect_out(0, -1, 15, 0, "R7");
    do_ack();
    expect_out(0, -1, 15, 0, "R12 no irq");
    do_eoi();
    expect_out(0, -1, 15, 1, "R11");
    tick();
    expect_out(0, -1, 15, 1, "R11 sticky");

    set_prio(20, 0); hw_req = '0; set_cur(0);
    for (int i = 0; i < 16; i++) begin
      if (i < N_SW) set_sw(i, 1);
      else hw_req[i - N_SW] = 1;
      set_prio(i, 1);
    end
    for (int i = 0; i < 16; i++) begin
      set_cur(0); tick();
      expect_out(1, i, 0, -1, "R12 fill");
      do_ack();
      expect_out(0, -1, 1, -1, "R9 fill");
    end
    hw_req[8] = 1; set_prio(16, 1); set_cur(0); tick();
    expect_out(1, 16, 0, -1, "R12 full");
    do_ack();
    expect_out(1, 16, 0, -1, "R12 full ack ignored");
    for (int i = 0; i < 16; i++) begin
      do_eoi();
      expect_out(irq, -1, 0, 1, "R10 drain");
    end
    do_eoi();
    expect_out(irq, -1, 0, 1, "R11 drained");

    tick();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule